// File: doc/BRIEF.md
# Dual-Port Tag-Searched CAM

This block is a small content addressable memory with two ports. Each entry holds a tag and a 32-bit data word. Entries are never addressed from outside. The write port supplies a tag and data pair, and an internal fill pointer places the pair in the next unused entry. The pointer starts at entry 0 after reset and moves forward by one entry for each accepted write.

The search port presents a tag. That tag is compared in parallel with the tag of every valid entry. One clock later the block reports a hit flag and the data word of the matching entry. On a miss the data output is zero. If more than one valid entry matches, the entry with the lowest index supplies the data.

Both request strobes are active low. When they are asserted in the same cycle, the write is carried out. The search tag is cut off from the comparators for that cycle, and a stall output tells the searching side to try again. Once every entry has been written, a full flag rises and further writes are dropped. Entries cannot be removed except by reset.

Top module: `tag_cam`

## Requirements
- R1: While reset is active and after it is released, hit is 0, the data output is 0, full is 0, and stall is 0 when both strobes are high.
- R2: A write (wr_n low, not full) stores its tag and data in the entry the fill pointer selects. The pointer starts at entry 0 after reset, and the stored pair can be found by a later search.
- R3: A search is accepted when rd_n is low and wr_n is high. In the next cycle hit is 1 and the data output carries the data of the matching valid entry.
- R4: The fill pointer advances by exactly one entry per accepted write. After DEPTH accepted writes, full is 1 from the following cycle.
- R5: When wr_n and rd_n are both low, stall is 1 in the same cycle and the write is performed. No search is done, so hit and the data output keep their previous values in the next cycle.
- R6: In any cycle without an accepted search, hit and the data output keep their values.
- R7: While full is 1, writes are ignored. Full stays 1, the pointer does not move, and the stored contents are unchanged, so a tag offered in an ignored write is not found.
- R8: A search that matches no valid entry gives hit 0 and data output 0. Entries that have not been written since reset never match, whatever tag is searched, including tag 0.
- R9: When several valid entries hold the searched tag, the data of the lowest-index one is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_n | input | 1 | Write request strobe, active low |
| wr_tag | input | TAG_W | Tag to store |
| wr_data | input | 32 | Data word to store |
| rd_n | input | 1 | Search request strobe, active low |
| rd_tag | input | TAG_W | Tag to search for |
| stall | output | 1 | Search held off this cycle because a write has priority |
| full | output | 1 | Every entry has been written |
| hit | output | 1 | Last accepted search found a valid match |
| rd_data | output | 32 | Data of the last accepted search, zero on a miss |

## Verification
The assertions are checked on every clock. They cover these properties:
- hit and the data output hold whenever no search is accepted, including stalled cycles.
- The data output is zero whenever hit is low.
- Full is sticky.
- The fill pointer steps by one per accepted write and freezes while full.

Other behaviour needs the bench's reference model and scenarios:
- that a search returns the right word;
- that the lowest-index entry wins among duplicate tags;
- that entries not yet written stay invisible;
- that a write dropped while full leaves its tag unfindable.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cam_fill_ctrl.sv
module cam_fill_ctrl #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  output logic                       accept,
  output logic [$clog2(DEPTH)-1:0]   idx,
  output logic                       full
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign accept = push & ~full;
  assign idx    = IDX_W'(cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (accept) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we,
  input  logic [$clog2(DEPTH)-1:0]              widx,
  input  logic [TAG_W-1:0]                      wtag,
  input  cam_pkg::word_t                        wdata,
  output logic [DEPTH-1:0][TAG_W-1:0]           tags,
  output cam_pkg::word_t [DEPTH-1:0]            words,
  output logic [DEPTH-1:0]                      valid
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic sel;
    assign sel = we & (widx == ($clog2(DEPTH))'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid[i] <= 1'b0;
      else if (sel) valid[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tags[i]  <= wtag;
        words[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cam_match.sv
module cam_match #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 8
) (
  input  logic [TAG_W-1:0]                key,
  input  logic [DEPTH-1:0][TAG_W-1:0]     tags,
  input  cam_pkg::word_t [DEPTH-1:0]      words,
  input  logic [DEPTH-1:0]                valid,
  output logic                            any,
  output cam_pkg::word_t                  word
);
  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = valid[i] & (tags[i] == key);
  end

  assign any = |eq;

  always_comb begin
    word = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) word = words[i];
    end
  end
endmodule

// File: rtl/tag_cam.sv
module tag_cam #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_n,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [31:0]          wr_data,
  input  logic                 rd_n,
  input  logic [TAG_W-1:0]     rd_tag,
  output logic                 stall,
  output logic                 full,
  output logic                 hit,
  output logic [31:0]          rd_data
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic                           fill_ok;
  logic [IDX_W-1:0]               fill_idx;
  logic [DEPTH-1:0][TAG_W-1:0]    ent_tag;
  cam_pkg::word_t [DEPTH-1:0]     ent_word;
  logic [DEPTH-1:0]               ent_vld;
  logic                           search;
  logic [TAG_W-1:0]               key;
  logic                           m_any;
  cam_pkg::word_t                 m_word;
  logic                           hit_d;
  cam_pkg::word_t                 data_d;

  assign stall  = ~wr_n & ~rd_n;
  assign search = ~rd_n & wr_n;
  assign key    = search ? rd_tag : '0;

  cam_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n), .push(~wr_n),
    .accept(fill_ok), .idx(fill_idx), .full(full)
  );

  cam_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(fill_ok), .widx(fill_idx),
    .wtag(wr_tag), .wdata(wr_data),
    .tags(ent_tag), .words(ent_word), .valid(ent_vld)
  );

  cam_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .key(key), .tags(ent_tag), .words(ent_word), .valid(ent_vld),
    .any(m_any), .word(m_word)
  );

  always_comb begin
    hit_d  = hit;
    data_d = rd_data;
    if (search) begin
      hit_d  = m_any;
      data_d = m_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      rd_data <= '0;
    end else begin
      hit     <= hit_d;
      rd_data <= data_d;
    end
  end
endmodule

// File: rtl/cam_chk.sv
module cam_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_n,
  input logic                     rd_n,
  input logic                     stall,
  input logic                     full,
  input logic                     hit,
  input logic [31:0]              rd_data,
  input logic                     fill_ok,
  input logic [$clog2(DEPTH)-1:0] fill_idx
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(hit) && $stable(rd_data)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_n && !rd_n) |=> ($stable(hit) && $stable(rd_data)));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data == '0));

  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  p_full_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n) |=> (full && $stable(fill_idx)));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && fill_idx != IDX_W'(DEPTH - 1)) |=> (fill_idx == $past(fill_idx) + IDX_W'(1)));

  p_last_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && fill_idx == IDX_W'(DEPTH - 1)) |=> full);
endmodule

bind tag_cam cam_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .stall(stall),
  .full(full), .hit(hit), .rd_data(rd_data),
  .fill_ok(fill_ok), .fill_idx(fill_idx)
);

// File: tb/sim_tag_cam.sv
`timescale 1ns/1ps
module sim_tag_cam;
  localparam int DEPTH = 16;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_n, rd_n;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [31:0] wr_data;
  logic stall, full, hit;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_tag(wr_tag), .wr_data(wr_data),
    .rd_n(rd_n), .rd_tag(rd_tag), .stall(stall), .full(full), .hit(hit),
    .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [31:0]      m_data [DEPTH];
  int               m_cnt;
  logic             e_hit;
  logic [31:0]      e_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_hit(input logic [TAG_W-1:0] t);
    for (int i = 0; i < m_cnt; i++) if (m_tag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_data(input logic [TAG_W-1:0] t);
    for (int i = 0; i < m_cnt; i++) if (m_tag[i] == t) return m_data[i];
    return 32'h0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    wr_tag = '0; rd_tag = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(hit == 1'b0 && rd_data == 32'h0 && full == 1'b0 && stall == 1'b0,
        "R1 reset", {full, stall, hit}, 32'h0);
    rst_n = 1'b1;
    m_cnt = 0; e_hit = 1'b0; e_data = 32'h0;
    @(negedge clk);
    chk(hit == 1'b0 && rd_data == 32'h0 && full == 1'b0, "R1 after release",
        {full, hit}, 32'h0);
  endtask

  // Called at a falling edge; checks stall at once and registered outputs one edge later.
  task automatic step(input bit w, input bit r, input logic [TAG_W-1:0] wt,
                      input logic [31:0] wd, input logic [TAG_W-1:0] rt);
    wr_n = ~w; rd_n = ~r; wr_tag = wt; wr_data = wd; rd_tag = rt;
    #1;
    chk(stall == (w && r), "R5 stall", 32'(stall), 32'(w && r));
    if (r && !w) begin
      e_hit  = ref_hit(rt);
      e_data = ref_data(rt);
    end
    if (w && m_cnt < DEPTH) begin
      m_tag[m_cnt]  = wt;
      m_data[m_cnt] = wd;
      m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(hit == e_hit, (r && !w) ? "R3/R8/R9 hit" : "R5/R6 hit held", 32'(hit), 32'(e_hit));
    chk(rd_data == e_data, (r && !w) ? "R3/R8/R9 data" : "R5/R6 data held", rd_data, e_data);
    chk(full == (m_cnt == DEPTH), "R4/R7 full", 32'(full), 32'(m_cnt == DEPTH));
    wr_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R8: unwritten entries never match, including tag 0
    step(0, 1, 8'h00, 32'h0, 8'h00);
    step(0, 1, 8'h00, 32'h0, 8'h5a);
    // R2, R3: first write lands in entry 0 and is found
    step(1, 0, 8'h11, 32'hAAAA_0001, 8'h00);
    step(0, 1, 8'h00, 32'h0, 8'h11);
    // R6: idle keeps the result
    step(0, 0, 8'h00, 32'h0, 8'h00);
    // R9: duplicate tag, lowest index wins
    step(1, 0, 8'h11, 32'hBBBB_0002, 8'h00);
    step(0, 1, 8'h00, 32'h0, 8'h11);
    // R5: simultaneous write and search, write performed, result held
    step(1, 1, 8'h22, 32'hCCCC_0003, 8'h22);
    step(0, 1, 8'h00, 32'h0, 8'h22);
    // R8: miss gives zero
    step(0, 1, 8'h00, 32'h0, 8'h99);
    // R4, R7: fill to full, then an ignored write
    while (m_cnt < DEPTH) step(1, 0, 8'h40 + 8'(m_cnt), 32'h1000 + 32'(m_cnt), 8'h00);
    step(1, 0, 8'hEE, 32'hDEAD_BEEF, 8'h00);
    step(0, 1, 8'h00, 32'h0, 8'hEE);
    step(0, 1, 8'h00, 32'h0, 8'h4f);
    step(0, 1, 8'h00, 32'h0, 8'h11);
    // random phases
    for (int ph = 0; ph < 3; ph++) begin
      do_reset();
      for (int k = 0; k < 200; k++) begin
        bit w, r;
        w = ($urandom % 6) == 0;
        r = ($urandom % 2) == 0;
        step(w, r, 8'($urandom % 8), $urandom, 8'($urandom % 8));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule